// File: doc/BRIEF.md
# Multiprocessor UART Receive Address Filter

This block sits behind the character assembler of a 9-bit multiprocessor UART receiver. Each received character arrives as a data byte plus a ninth flag bit, where a flag of 1 marks an address character and 0 marks a data character. The block decides whether that character should raise a receive interrupt request and forwards the byte, its flag and that decision through a one-deep output register.

The decision is set by an enable bit, a 2-bit mode and a compare register. Some modes track whether the most recent address character matched the compare value, and carry that result across the data characters that follow it.

Both the character input and the output are valid/ready streams. A character is taken on a cycle where `in_valid` and `in_ready` are both high. The output register holds its beat until the consumer raises `out_ready`. `in_ready` is high whenever the register is empty or is being drained in the same cycle, so back-pressure reaches the input with no added cycle. Characters are never dropped: the filter only decides the interrupt.

Top module: `mp_addr_filter`

## Requirements
- R1: After reset `out_valid` and `irq_pulse` are 0, and the stored match state reads as non-matching, so in mode 3 a data character sent before any address raises no request.
- R2: With `mp_en` = 0 every accepted character raises a request, and the flag bit is passed through unchanged to `out_flag`.
- R3: With `mp_en` = 1 and mode 0, every accepted character raises a request, whether it is an address (flag 1) or data (flag 0).
- R4: With `mp_en` = 1 and mode 1, a request is raised exactly for address characters (flag 1).
- R5: With `mp_en` = 1 and mode 2, an address character equal to `addr_cmp` raises a request and so does each data character after it. An address character that differs from `addr_cmp` raises none, and neither do the data characters after it.
- R6: With `mp_en` = 1 and mode 3, address characters never raise a request, and a data character raises one only if the most recent address character matched `addr_cmp`.
- R7: A character accepted at a clock edge appears on `out_data`, `out_flag` and `out_irq` with `out_valid` = 1 after that edge. `irq_pulse` is high for exactly that one cycle when the decision is to interrupt.
- R8: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and the output beat is held stable. `in_ready` equals `!out_valid || out_ready`.
- R9: A new mode or compare value applies from the next accepted character. The stored match state is updated by every address character accepted while `mp_en` = 1, in any mode, and is kept across mode and compare changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mp_en | input | 1 | Enable 9-bit address filtering |
| mode | input | 2 | Filter mode 0..3 |
| addr_cmp | input | DATA_W | Station address to compare |
| in_valid | input | 1 | Received character valid |
| in_ready | output | 1 | Filter can take a character |
| in_data | input | DATA_W | Received byte |
| in_flag | input | 1 | Ninth bit, 1 = address |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | DATA_W | Forwarded byte |
| out_flag | output | 1 | Forwarded ninth bit |
| out_irq | output | 1 | Interrupt decision for the held beat |
| irq_pulse | output | 1 | One-cycle receive interrupt request |

## Verification
The bench builds the block with the default 8-bit data width. This lets it use compare values at both ends of the byte range (0x00 and 0xFF) as well as mid-range station addresses. A one-bit difference between a received address and the compare register therefore counts as a mismatch. The directed tasks switch mode and compare value between characters to reach the kept-match cases, and they hold `out_ready` low to reach the stall path of the output register.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  typedef enum logic [1:0] {
    MPF_ALL    = 2'd0,
    MPF_ADDR   = 2'd1,
    MPF_WINDOW = 2'd2,
    MPF_DATA   = 2'd3
  } mpf_mode_e;
endpackage

// File: rtl/mpf_match_track.sv
module mpf_match_track (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic hit,
  output logic match_q
);
  // An address character sets or clears the match state. Reset leaves it clear.
  always_ff @(posedge clk) begin
    if (!rst_n)   match_q <= 1'b0;
    else if (upd) match_q <= hit;
  end
endmodule

// File: rtl/mpf_irq_decide.sv
module mpf_irq_decide
  import mpf_pkg::*;
(
  input  logic      mp_en,
  input  mpf_mode_e mode,
  input  logic      is_addr,
  input  logic      hit,
  input  logic      match_q,
  output logic      raise
);
  always_comb begin
    if (!mp_en) begin
      raise = 1'b1;
    end else begin
      unique case (mode)
        MPF_ALL:    raise = 1'b1;
        MPF_ADDR:   raise = is_addr;
        MPF_WINDOW: raise = is_addr ? hit : match_q;
        MPF_DATA:   raise = !is_addr && match_q;
        default:    raise = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mpf_out_stage.sv
module mpf_out_stage #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_beat,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_beat
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_beat  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_beat  <= in_beat;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter
  import mpf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mp_en,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] addr_cmp,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_flag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_flag,
  output logic              out_irq,
  output logic              irq_pulse
);
  localparam int BEAT_W = DATA_W + 2;

  logic              take;
  logic              hit;
  logic              match_q;
  logic              raise;
  logic [BEAT_W-1:0] beat_in;
  logic [BEAT_W-1:0] beat_out;

  assign take = in_valid && in_ready;
  assign hit  = (in_data == addr_cmp);

  mpf_match_track u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (take && mp_en && in_flag),
    .hit     (hit),
    .match_q (match_q)
  );

  mpf_irq_decide u_decide (
    .mp_en   (mp_en),
    .mode    (mpf_mode_e'(mode)),
    .is_addr (in_flag),
    .hit     (hit),
    .match_q (match_q),
    .raise   (raise)
  );

  assign beat_in = {raise, in_flag, in_data};

  mpf_out_stage #(.W(BEAT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_beat   (beat_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_beat  (beat_out)
  );

  assign out_data = beat_out[DATA_W-1:0];
  assign out_flag = beat_out[DATA_W];
  assign out_irq  = beat_out[DATA_W+1];

  always_ff @(posedge clk) begin
    if (!rst_n) irq_pulse <= 1'b0;
    else        irq_pulse <= take && raise;
  end
endmodule

// File: rtl/mp_addr_filter_chk.sv
module mp_addr_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mp_en,
  input logic [1:0]        mode,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              in_flag,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_flag,
  input logic              out_irq,
  input logic              irq_pulse
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_flag) && $stable(out_irq));

  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid && out_data == $past(in_data) && out_flag == $past(in_flag));

  a_r7_pulse_matches_beat: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> out_valid && out_irq);

  a_r2_bypass_raises: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !mp_en |=> irq_pulse);

  a_r3_all_raise: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mp_en && mode == 2'd0 |=> irq_pulse);

  a_r4_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mp_en && mode == 2'd1 |=> irq_pulse == out_flag);

  a_r6_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    acc && mp_en && mode == 2'd3 && in_flag |=> !irq_pulse);
endmodule

bind mp_addr_filter mp_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mp_en(mp_en), .mode(mode),
  .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_flag(in_flag),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_flag(out_flag), .out_irq(out_irq), .irq_pulse(irq_pulse)
);

// File: tb/mp_addr_filter_tb_top.sv
`timescale 1ns/1ps
module mp_addr_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mp_en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] addr_cmp = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_flag = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_flag;
  logic       out_irq;
  logic       irq_pulse;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  mp_addr_filter #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .mp_en(mp_en), .mode(mode), .addr_cmp(addr_cmp),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_flag(in_flag),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_flag(out_flag), .out_irq(out_irq), .irq_pulse(irq_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Present one character with out_ready high, then check the registered beat.
  task automatic send(input logic [7:0] d, input logic f, input logic exp_irq, input string tag);
    @(negedge clk);
    in_data = d; in_flag = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(irq_pulse == exp_irq, {tag, " irq_pulse"}, irq_pulse, exp_irq);
    chk(out_valid && out_data == d && out_flag == f && out_irq == exp_irq,
        {tag, " beat"}, {out_valid, out_irq, out_flag, out_data}, {1'b1, exp_irq, f, d});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk(!out_valid && !irq_pulse, "R1 reset outputs", {out_valid, irq_pulse}, 0);
    mp_en = 1'b1; mode = 2'd3; addr_cmp = 8'h00;
    send(8'h11, 1'b0, 1'b0, "R1 data before any address");
  endtask

  task automatic t_bypass();
    do_reset();
    mp_en = 1'b0; mode = 2'd3; addr_cmp = 8'h42;
    send(8'h99, 1'b1, 1'b1, "R2 flag1 bypass");
    send(8'h01, 1'b0, 1'b1, "R2 flag0 bypass");
  endtask

  task automatic t_mode00();
    do_reset();
    mp_en = 1'b1; mode = 2'd0; addr_cmp = 8'h42;
    send(8'h10, 1'b1, 1'b1, "R3 address");
    send(8'h20, 1'b0, 1'b1, "R3 data");
  endtask

  task automatic t_mode01();
    do_reset();
    mp_en = 1'b1; mode = 2'd1; addr_cmp = 8'h42;
    send(8'h42, 1'b1, 1'b1, "R4 address");
    send(8'h42, 1'b0, 1'b0, "R4 data");
    send(8'h07, 1'b1, 1'b1, "R4 other address");
  endtask

  task automatic t_mode10();
    do_reset();
    mp_en = 1'b1; mode = 2'd2; addr_cmp = 8'hFF;
    send(8'h33, 1'b0, 1'b0, "R5 data before address");
    send(8'hFF, 1'b1, 1'b1, "R5 matching address");
    send(8'h01, 1'b0, 1'b1, "R5 data in window");
    send(8'h02, 1'b0, 1'b1, "R5 second data in window");
    send(8'hFE, 1'b1, 1'b0, "R5 mismatching address");
    send(8'h03, 1'b0, 1'b0, "R5 data after mismatch");
  endtask

  task automatic t_mode11();
    do_reset();
    mp_en = 1'b1; mode = 2'd3; addr_cmp = 8'h00;
    send(8'h00, 1'b1, 1'b0, "R6 matching address quiet");
    send(8'hAA, 1'b0, 1'b1, "R6 data after match");
    send(8'h80, 1'b1, 1'b0, "R6 mismatching address");
    send(8'hAB, 1'b0, 1'b0, "R6 data after mismatch");
  endtask

  task automatic t_change();
    do_reset();
    mp_en = 1'b1; mode = 2'd1; addr_cmp = 8'h42;
    send(8'h42, 1'b1, 1'b1, "R9 match in mode1");
    mode = 2'd3;
    send(8'h05, 1'b0, 1'b1, "R9 match kept into mode3");
    addr_cmp = 8'h55;
    send(8'h06, 1'b0, 1'b1, "R9 compare change keeps match");
    mode = 2'd2;
    send(8'h42, 1'b1, 1'b0, "R9 new compare applies");
    send(8'h07, 1'b0, 1'b0, "R9 window closed");
  endtask

  task automatic t_backpressure();
    do_reset();
    mp_en = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    in_data = 8'hA1; in_flag = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk(irq_pulse && out_valid && out_data == 8'hA1, "R7 first beat loaded", out_data, 8'hA1);
    in_data = 8'hB2; in_flag = 1'b1;
    chk(!in_ready, "R8 ready low while stalled", in_ready, 0);
    @(negedge clk);
    chk(!irq_pulse, "R7 pulse lasts one cycle", irq_pulse, 0);
    @(negedge clk);
    chk(out_valid && out_data == 8'hA1 && !out_flag, "R8 beat held", out_data, 8'hA1);
    chk(!in_ready, "R8 still stalled", in_ready, 0);
    out_ready = 1'b1;
    #1;
    chk(in_ready, "R8 ready follows out_ready", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data == 8'hB2 && out_flag, "R8 second beat after drain", out_data, 8'hB2);
    @(negedge clk);
    chk(!out_valid, "R8 register drains empty", out_valid, 0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_bypass();
    t_mode00();
    t_mode01();
    t_mode10();
    t_mode11();
    t_change();
    t_backpressure();
    finish_run();
  end
endmodule